// File: doc/BRIEF.md
# External and Pin-Change Interrupt Flag Unit

This block keeps the pending-interrupt flags and one interrupt mask of a small 8-bit microcontroller. It watches one synchronised external interrupt input and a group of synchronised general-purpose inputs. It latches a flag when the selected kind of event occurs. It combines each flag with its source enable and the global interrupt enable, and presents the winning vector number to the core.

Software reaches the block through a byte-wide I/O port. The flag register clears a bit when a one is written to it. A flag also clears when the core acknowledges the vector that the flag raised. In level-sensitive mode the external input requests directly while the pin is low, and its flag stays cleared. The timer overflow flag comes from the timer itself; this block holds only its enable bit.

Top module: `irq_flag_unit`

## Requirements
- R1: After reset the flag register (I/O address 0x3A) and the mask register (address 0x39) both read 0x00, and `irq_req` is low with `irq_vec` equal to 0.
- R2: In the flag register only bit 6 (external flag) and bit 5 (pin-change flag) can read as one. In the mask register only bit 1 (timer overflow enable) can read as one, and it holds the value last written to that bit. Writes to the other bits have no effect, and those bits read zero.
- R3: The external flag sets on the clock edge at which the pin differs from its value one cycle earlier. The `ext_mode` setting selects which differences count: 01 counts either direction, 10 counts only 1→0, and 11 counts only 0→1. The first cycle after reset never counts as an event.
- R4: While `ext_mode` is 00 (low level), the external flag is cleared and stays clear. The external request is active for as long as `ext_pin` is low, `ext_en` is high and `gie` is high.
- R5: The pin-change flag sets one cycle after any bit of `pc_pins` changes in either direction.
- R6: Writing a one to a flag bit clears that flag. Writing a zero leaves the flag unchanged.
- R7: An `irq_ack` pulse clears the flag that belongs to the vector on `irq_vec` in that cycle, and only that flag.
- R8: When a hardware event and a write-one-clear reach the same flag in the same cycle, the flag ends up set.
- R9: A source requests only when its flag (or the low level in R4), its enable and `gie` are all high. The vectors are 1 for the external input, 2 for pin change and 3 for timer overflow. `irq_vec` is 0 when nothing is requested.
- R10: When several sources request at once, `irq_vec` shows the lowest vector number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 6 | I/O register address |
| io_we | input | 1 | Write strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Read data for `io_addr` (combinational) |
| ext_pin | input | 1 | Synchronised external interrupt input |
| ext_mode | input | 2 | Sense: 00 low, 01 any change, 10 falling, 11 rising |
| ext_en | input | 1 | External interrupt source enable |
| pc_pins | input | NPC | Synchronised monitored inputs |
| pc_en | input | 1 | Pin-change source enable |
| tov_flag | input | 1 | Timer overflow flag from the timer |
| gie | input | 1 | Global interrupt enable |
| irq_ack | input | 1 | Core acknowledges the vector on `irq_vec` |
| irq_req | output | 1 | Interrupt request |
| irq_vec | output | VEC_W | Requested vector number |

## Verification
A pin event that is present before a clock edge shows up as a flag on the read port and on `irq_req` right after that edge. A write-one-clear or an acknowledge takes effect at the edge on which it is present. The bench therefore drives each stimulus one time unit after an edge and reads one edge later. Read data, the level-mode request and the enable or `gie` gating are combinational, so the bench checks them before the next edge. The sweeps cover every sense mode in both pin directions, every monitored pin in both directions, and every combination of enables.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        SENSE_LOW  = 2'b00,
        SENSE_ANY  = 2'b01,
        SENSE_FALL = 2'b10,
        SENSE_RISE = 2'b11
    } sense_e;

    localparam int NUM_SRC = 3;
    localparam int VEC_EXT = 1;
    localparam int VEC_PC  = 2;
    localparam int VEC_TOV = 3;
endpackage

// File: rtl/irq_edge_detect.sv
module irq_edge_detect
    import irq_pkg::*;
(
    input  logic       pin_now,
    input  logic       pin_prev,
    input  logic       primed,
    input  logic [1:0] mode,
    output logic       evt
);
    logic rise, fall;

    always_comb begin
        rise = primed & pin_now & ~pin_prev;
        fall = primed & ~pin_now & pin_prev;
        unique case (sense_e'(mode))
            SENSE_ANY:  evt = rise | fall;
            SENSE_FALL: evt = fall;
            SENSE_RISE: evt = rise;
            default:    evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/irq_change_detect.sv
module irq_change_detect #(
    parameter int N = 4
) (
    input  logic [N-1:0] now,
    input  logic [N-1:0] prev,
    input  logic         primed,
    output logic         evt
);
    logic [N-1:0] diff;

    genvar g;
    generate
        for (g = 0; g < N; g++) begin : g_bit
            assign diff[g] = now[g] ^ prev[g];
        end
    endgenerate

    assign evt = primed & (|diff);
endmodule

// File: rtl/irq_prio.sv
module irq_prio
    import irq_pkg::*;
#(
    parameter int VEC_W = 4
) (
    input  logic [NUM_SRC-1:0] src_req,
    output logic               irq_req,
    output logic [VEC_W-1:0]   irq_vec
);
    always_comb begin
        irq_vec = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (src_req[i]) irq_vec = VEC_W'(i + 1);
        end
        irq_req = |src_req;
    end
endmodule

// File: rtl/irq_flag_unit.sv
module irq_flag_unit
    import irq_pkg::*;
#(
    parameter int           NPC       = 4,
    parameter int           ADDR_W    = 6,
    parameter int           DATA_W    = 8,
    parameter int           VEC_W     = 4,
    parameter logic [5:0]   FLAG_ADDR = 6'h3A,
    parameter logic [5:0]   MASK_ADDR = 6'h39,
    parameter int           EXT_BIT   = 6,
    parameter int           PC_BIT    = 5,
    parameter int           TOV_BIT   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] io_addr,
    input  logic              io_we,
    input  logic [DATA_W-1:0] io_wdata,
    output logic [DATA_W-1:0] io_rdata,
    input  logic              ext_pin,
    input  logic [1:0]        ext_mode,
    input  logic              ext_en,
    input  logic [NPC-1:0]    pc_pins,
    input  logic              pc_en,
    input  logic              tov_flag,
    input  logic              gie,
    input  logic              irq_ack,
    output logic              irq_req,
    output logic [VEC_W-1:0]  irq_vec
);
    typedef struct packed {
        logic           ext_flag;
        logic           pc_flag;
        logic           tov_ie;
        logic           ext_prev;
        logic [NPC-1:0] pc_prev;
        logic           primed;
    } state_t;

    state_t st_d, st_q;

    logic               ext_evt, pc_evt;
    logic               level_mode;
    logic               wr_flag, wr_mask;
    logic               ack_ext, ack_pc;
    logic [NUM_SRC-1:0] src_req;

    irq_edge_detect u_edge (
        .pin_now (ext_pin),
        .pin_prev(st_q.ext_prev),
        .primed  (st_q.primed),
        .mode    (ext_mode),
        .evt     (ext_evt)
    );

    irq_change_detect #(.N(NPC)) u_change (
        .now   (pc_pins),
        .prev  (st_q.pc_prev),
        .primed(st_q.primed),
        .evt   (pc_evt)
    );

    irq_prio #(.VEC_W(VEC_W)) u_prio (
        .src_req(src_req),
        .irq_req(irq_req),
        .irq_vec(irq_vec)
    );

    always_comb begin
        level_mode = (sense_e'(ext_mode) == SENSE_LOW);
        wr_flag    = io_we && (io_addr == ADDR_W'(FLAG_ADDR));
        wr_mask    = io_we && (io_addr == ADDR_W'(MASK_ADDR));
        ack_ext    = irq_ack && (irq_vec == VEC_W'(VEC_EXT));
        ack_pc     = irq_ack && (irq_vec == VEC_W'(VEC_PC));

        // request sources, index = vector - 1
        src_req[VEC_EXT-1] = gie & ext_en &
                             (level_mode ? ~ext_pin : st_q.ext_flag);
        src_req[VEC_PC-1]  = gie & pc_en & st_q.pc_flag;
        src_req[VEC_TOV-1] = gie & st_q.tov_ie & tov_flag;

        st_d          = st_q;
        st_d.primed   = 1'b1;
        st_d.ext_prev = ext_pin;
        st_d.pc_prev  = pc_pins;

        // clears first, hardware set last so the set wins
        if (wr_flag && io_wdata[EXT_BIT]) st_d.ext_flag = 1'b0;
        if (ack_ext)                      st_d.ext_flag = 1'b0;
        if (ext_evt)                      st_d.ext_flag = 1'b1;
        if (level_mode)                   st_d.ext_flag = 1'b0;

        if (wr_flag && io_wdata[PC_BIT])  st_d.pc_flag = 1'b0;
        if (ack_pc)                       st_d.pc_flag = 1'b0;
        if (pc_evt)                       st_d.pc_flag = 1'b1;

        if (wr_mask) st_d.tov_ie = io_wdata[TOV_BIT];

        io_rdata = '0;
        if (io_addr == ADDR_W'(FLAG_ADDR)) begin
            io_rdata[EXT_BIT] = st_q.ext_flag;
            io_rdata[PC_BIT]  = st_q.pc_flag;
        end else if (io_addr == ADDR_W'(MASK_ADDR)) begin
            io_rdata[TOV_BIT] = st_q.tov_ie;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/irq_flag_unit_chk.sv
module irq_flag_unit_chk #(
    parameter int         ADDR_W    = 6,
    parameter int         DATA_W    = 8,
    parameter int         VEC_W     = 4,
    parameter logic [5:0] FLAG_ADDR = 6'h3A,
    parameter int         EXT_BIT   = 6,
    parameter int         PC_BIT    = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] io_addr,
    input logic              io_we,
    input logic [DATA_W-1:0] io_wdata,
    input logic [DATA_W-1:0] io_rdata,
    input logic [1:0]        ext_mode,
    input logic              ext_flag,
    input logic              pc_flag,
    input logic              pc_evt,
    input logic              gie,
    input logic              irq_ack,
    input logic              irq_req,
    input logic [VEC_W-1:0]  irq_vec
);
    logic [DATA_W-1:0] flag_keep;
    always_comb begin
        flag_keep          = '0;
        flag_keep[EXT_BIT] = 1'b1;
        flag_keep[PC_BIT]  = 1'b1;
    end

    p_reserved_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (io_addr == ADDR_W'(FLAG_ADDR)) |-> ((io_rdata & ~flag_keep) == '0));

    p_level_holds_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_mode == 2'b00) |=> !ext_flag);

    p_w1c_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (io_we && io_addr == ADDR_W'(FLAG_ADDR) && io_wdata[PC_BIT] && !pc_evt) |=> !pc_flag);

    p_ack_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_vec == VEC_W'(2) && !pc_evt) |=> !pc_flag);

    p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
        pc_evt |=> pc_flag);

    p_gie_gates_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !gie |-> (!irq_req && irq_vec == '0));
endmodule

bind irq_flag_unit irq_flag_unit_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .VEC_W(VEC_W),
    .FLAG_ADDR(FLAG_ADDR), .EXT_BIT(EXT_BIT), .PC_BIT(PC_BIT)
) u_chk (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_we(io_we),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .ext_mode(ext_mode),
    .ext_flag(st_q.ext_flag), .pc_flag(st_q.pc_flag), .pc_evt(pc_evt),
    .gie(gie), .irq_ack(irq_ack), .irq_req(irq_req), .irq_vec(irq_vec)
);

// File: tb/irq_flag_unit_test.sv
module irq_flag_unit_test;
    localparam int NPC = 4;
    localparam logic [5:0] FA = 6'h3A;
    localparam logic [5:0] MA = 6'h39;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] io_addr = FA;
    logic       io_we = 1'b0;
    logic [7:0] io_wdata = '0;
    logic [7:0] io_rdata;
    logic       ext_pin = 1'b0;
    logic [1:0] ext_mode = 2'b01;
    logic       ext_en = 1'b0;
    logic [NPC-1:0] pc_pins = '0;
    logic       pc_en = 1'b0;
    logic       tov_flag = 1'b0;
    logic       gie = 1'b0;
    logic       irq_ack = 1'b0;
    logic       irq_req;
    logic [3:0] irq_vec;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    irq_flag_unit uut (
        .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_we(io_we),
        .io_wdata(io_wdata), .io_rdata(io_rdata), .ext_pin(ext_pin),
        .ext_mode(ext_mode), .ext_en(ext_en), .pc_pins(pc_pins),
        .pc_en(pc_en), .tov_flag(tov_flag), .gie(gie), .irq_ack(irq_ack),
        .irq_req(irq_req), .irq_vec(irq_vec)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        io_addr = a; io_wdata = d; io_we = 1'b1;
        tick();
        io_we = 1'b0; io_wdata = '0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        io_addr = a;
        #1;
        d = io_rdata;
    endtask

    task automatic summary();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        summary();
    end

    initial begin
        logic [7:0] r;
        #5;
        rst_n = 1'b1;
        tick();

        // R1 reset state
        rd(FA, r); chk("R1 flag reg", r, 0);
        rd(MA, r); chk("R1 mask reg", r, 0);
        chk("R1 irq_req", irq_req, 0);
        chk("R1 irq_vec", irq_vec, 0);

        // R2 reserved bits: write all ones
        wr(MA, 8'hFF); rd(MA, r); chk("R2 mask all ones", r, 8'h02);
        wr(MA, 8'hFD); rd(MA, r); chk("R2 mask bit1 cleared", r, 8'h00);
        wr(FA, 8'hFF); rd(FA, r); chk("R2 flag reserved", r, 8'h00);

        // R3 edge sweep: modes 1..3, both directions
        for (int m = 1; m <= 3; m++) begin
            for (int s = 0; s <= 1; s++) begin
                int exp;
                ext_mode = 2'(m);
                ext_pin = 1'(s);
                tick();
                wr(FA, 8'h40);
                rd(FA, r); chk("R3 precleared", r[6], 0);
                ext_pin = 1'(1 - s);
                tick();
                exp = (m == 1) ? 1 : (m == 2) ? s : 1 - s;
                rd(FA, r); chk($sformatf("R3 mode%0d start%0d", m, s), r[6], exp);
            end
        end

        // R6 writing zero keeps flag, writing one clears
        ext_mode = 2'b01; ext_pin = ~ext_pin; tick();
        wr(FA, 8'h00); rd(FA, r); chk("R6 write zero keeps", r[6], 1);
        wr(FA, 8'h40); rd(FA, r); chk("R6 write one clears", r[6], 0);

        // R5 pin change sweep
        for (int i = 0; i < NPC; i++) begin
            for (int dir = 0; dir <= 1; dir++) begin
                wr(FA, 8'h20);
                rd(FA, r); chk("R5 precleared", r[5], 0);
                pc_pins[i] = ~pc_pins[i];
                tick();
                rd(FA, r); chk($sformatf("R5 pin%0d dir%0d", i, dir), r[5], 1);
                chk("R5 ext unaffected", r[6], 0);
            end
        end

        // R8 set wins over write-one-clear
        pc_pins[0] = ~pc_pins[0];
        io_addr = FA; io_wdata = 8'h20; io_we = 1'b1;
        tick();
        io_we = 1'b0;
        rd(FA, r); chk("R8 set beats clear", r[5], 1);

        // R9 gating sweep on pin-change source (flag set)
        for (int gg = 0; gg <= 1; gg++) begin
            for (int en = 0; en <= 1; en++) begin
                gie = 1'(gg); pc_en = 1'(en);
                #1;
                chk($sformatf("R9 req g%0d e%0d", gg, en), irq_req, gg & en);
                chk($sformatf("R9 vec g%0d e%0d", gg, en), irq_vec, (gg & en) ? 2 : 0);
            end
        end
        // timer source gating
        pc_en = 1'b0; tov_flag = 1'b1;
        #1; chk("R9 timer disabled", irq_req, 0);
        wr(MA, 8'h02);
        chk("R9 timer vec", irq_vec, 3);

        // R10 priority
        ext_en = 1'b1; pc_en = 1'b1;
        ext_pin = ~ext_pin; tick();
        chk("R10 ext wins", irq_vec, 1);
        // R7 ack clears only ext
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        rd(FA, r); chk("R7 ack ext cleared", r[6], 0);
        chk("R7 pc kept", r[5], 1);
        chk("R10 pc over timer", irq_vec, 2);
        irq_ack = 1'b1; tick(); irq_ack = 1'b0;
        rd(FA, r); chk("R7 ack pc cleared", r[5], 0);
        chk("R10 timer last", irq_vec, 3);
        tov_flag = 1'b0;
        #1; chk("R9 none vec", irq_vec, 0);

        // R4 level mode
        ext_pin = ~ext_pin; tick();
        rd(FA, r); chk("R4 flag set before level", r[6], 1);
        ext_mode = 2'b00; ext_pin = 1'b1; tick();
        rd(FA, r); chk("R4 flag forced clear", r[6], 0);
        chk("R4 pin high no req", irq_req, 0);
        ext_pin = 1'b0; #1;
        chk("R4 pin low req", irq_req, 1);
        chk("R4 vec", irq_vec, 1);
        tick(); ext_pin = 1'b1; tick(); ext_pin = 1'b0; tick();
        rd(FA, r); chk("R4 flag stays clear", r[6], 0);
        gie = 1'b0; #1;
        chk("R4 gie gates level", irq_req, 0);

        summary();
    end
endmodule